// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control registers of a processor core. Software reaches each register by a small numeric index, through one read port and one write port. Each index has its own write behaviour. A write may store the full word, store only certain bits, or clear the register whatever the data. Some writes are refused with a fault. Others become commands to the instruction-side and data-side address translation buffers: flush everything, flush one process, flush one address, or install a new entry. The buffers themselves are outside this block. It only produces one-cycle strobes and the packed entry or address that goes with them.

Reads and writes are plain strobes with no stall. The bank never pushes back on a request, so the ready side of each port is implicitly always high. A read answers on the cycle after its request with a data word and a fault bit. The consumer must take the answer in that cycle, because the block holds no queue. A write takes effect at the clock edge where its strobe is high. Any fault, flush, fill or fill error that the write causes appears as a one-cycle pulse after that edge.

Top module: `preg_bank`

## Requirements
- R1: After reset every register reads zero and every strobe and fault output is low.
- R2: A read request gives `rsp_vld` high with its data on the cycle after the request edge. When a read and a write hit the same index in the same cycle, the read returns the value from before the write.
- R3: Indices 0 and 1 (scratch) and 17 (instruction tag) store and return all 64 bits.
- R4: Writes keep only these bits:
  - indices 2 and 3 (trap request and enable): bits 3:0
  - index 4 (priority level): bits 4:0
  - indices 5 and 6 (instruction and data mode): bits 4:3
  - index 7 (software interrupt request): bits 18:4
  - index 13 (data address-space number): bits 63:57
  - index 14 (instruction address-space number): bits 10:4
- R5: A write to index 8 (exception PC) stores the data with bit 1 forced to zero. A write of any value to index 9 or 10 (exception summary and mask) leaves them reading zero.
- R6: Faults are reported on `wr_fault` and `rsp_fault` in the cycle after the request:
  - A write to read-only index 12 raises `wr_fault`. Index 12 reads the parameter `CORE_ID`.
  - Reading a write-only index (16, 18, 19 to 24) raises `rsp_fault`.
  - Any index of 25 or more faults in both directions.
  - A faulting read returns zero data.
- R7: A read of index 11 returns bits 63:32 from its stored value and bits 31:0 from a free-running counter that advances once per clock. Two reads one cycle apart therefore differ by 1 in the low half.
- R8: A write to index 19, 20, 22 or 23 pulses, for exactly one cycle, data flush-all, data flush-process, instruction flush-all or instruction flush-process respectively.
- R9: A write to index 21 (data) or 24 (instruction) pulses the matching single-entry flush. The pulse carries the written address and the current 7-bit address-space number, taken from index 13 bits 63:57 for data or index 14 bits 10:4 for instruction.
- R10: A data fill takes two writes. Index 15 stages a page-table entry with this layout:
  - physical page at bits 58:32
  - read enables at bits 11:8
  - write enables at bits 15:12
  - fault-on-read at bit 1
  - fault-on-write at bit 2
  - any-space at bit 4
  - granularity hint at bits 6:5

  A later write to index 16 pulses `d_fill_vld` with the written tag and the 45-bit entry. The entry packs, from bit 44 down to bit 0: address-space number (7 bits), page (27), read enables (4), write enables (4), any-space, fault-on-write, fault-on-read.
- R11: If the granularity hint of the entry is nonzero, a fill write pulses `fill_err` instead of a fill. No fill strobe appears and the write is not stored. For a data fill the entry is the one staged at index 15. For an instruction fill it is the written word.
- R12: Reading index 15 returns the staged entry fields listed in R10, ORed with the data address-space number at bits 63:57. All other bits read zero.
- R13: A write to index 18 pulses `i_fill_vld` with an entry built from the written word in the R10 layout. The write enables are forced to zero, the tag is the value held at index 17, and the address-space number comes from index 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_vld | input | 1 | Read request strobe |
| rd_idx | input | IDX_W | Read index |
| rsp_vld | output | 1 | Read answer valid |
| rsp_data | output | 64 | Read answer data |
| rsp_fault | output | 1 | Read answer is a fault |
| wr_vld | input | 1 | Write request strobe |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Previous write faulted |
| fill_err | output | 1 | Previous fill refused for a nonzero granularity hint |
| d_inv_all | output | 1 | Data flush-all strobe |
| d_inv_proc | output | 1 | Data flush-process strobe |
| d_inv_one | output | 1 | Data single-address flush strobe |
| d_inv_addr | output | 64 | Data flush address |
| d_inv_asn | output | 7 | Data flush address-space number |
| d_fill_vld | output | 1 | Data fill strobe |
| d_fill_tag | output | 64 | Data fill tag |
| d_fill_ent | output | 45 | Data fill packed entry |
| i_inv_all | output | 1 | Instruction flush-all strobe |
| i_inv_proc | output | 1 | Instruction flush-process strobe |
| i_inv_one | output | 1 | Instruction single-address flush strobe |
| i_inv_addr | output | 64 | Instruction flush address |
| i_inv_asn | output | 7 | Instruction flush address-space number |
| i_fill_vld | output | 1 | Instruction fill strobe |
| i_fill_tag | output | 64 | Instruction fill tag |
| i_fill_ent | output | 45 | Instruction fill packed entry |

## Verification
The hardest case to reach is a data fill whose outcome depends on state left behind by earlier writes to other indices. The address-space register and the staged entry must both already hold chosen values when the tag write arrives. A nonzero granularity hint must then turn the same tag write into an error instead of an insert. The stimulus builds this up in order: it writes the address-space register, stages an entry with a clean hint and issues the tag, then restages with a dirty hint and repeats the tag. The same-cycle read and write is reached by raising both strobes on one index in one cycle.

// File: rtl/preg_pkg.sv
package preg_pkg;
  localparam int unsigned DW        = 64;
  localparam int unsigned ASN_W     = 7;
  localparam int unsigned PPN_W     = 27;
  localparam int unsigned EN_W      = 4;
  localparam int unsigned GH_W      = 2;
  localparam int unsigned CYC_LO_W  = 32;
  localparam int unsigned ENT_W     = ASN_W + PPN_W + 2 * EN_W + 3;

  // entry field positions inside a staged page-table word
  localparam int unsigned PPN_LSB   = 32;
  localparam int unsigned RDEN_LSB  = 8;
  localparam int unsigned WREN_LSB  = 12;
  localparam int unsigned FOR_BIT   = 1;
  localparam int unsigned FOW_BIT   = 2;
  localparam int unsigned ANY_BIT   = 4;
  localparam int unsigned GH_LSB    = 5;
  localparam int unsigned DASN_LSB  = 57;
  localparam int unsigned IASN_LSB  = 4;

  localparam logic [DW-1:0] PTE_FIELDS =
      ((((DW)'(1) << PPN_W) - 1) << PPN_LSB)
    | ((((DW)'(1) << EN_W) - 1) << RDEN_LSB)
    | ((((DW)'(1) << EN_W) - 1) << WREN_LSB)
    | ((DW)'(1) << FOR_BIT) | ((DW)'(1) << FOW_BIT) | ((DW)'(1) << ANY_BIT);
  localparam logic [DW-1:0] DASN_MASK = ((((DW)'(1) << ASN_W) - 1) << DASN_LSB);
  localparam logic [DW-1:0] IASN_MASK = ((((DW)'(1) << ASN_W) - 1) << IASN_LSB);

  // index map
  localparam int unsigned IX_SCR0 = 0,  IX_SCR1 = 1,  IX_TREQ = 2,  IX_TEN  = 3;
  localparam int unsigned IX_PRI  = 4,  IX_IMOD = 5,  IX_DMOD = 6,  IX_SWI  = 7;
  localparam int unsigned IX_EPC  = 8,  IX_ESUM = 9,  IX_EMSK = 10, IX_CYC  = 11;
  localparam int unsigned IX_CORE = 12, IX_DASN = 13, IX_IASN = 14, IX_DPTE = 15;
  localparam int unsigned IX_DTAG = 16, IX_ITAG = 17, IX_IPTE = 18, IX_DALL = 19;
  localparam int unsigned IX_DPRC = 20, IX_DONE = 21, IX_IALL = 22, IX_IPRC = 23;
  localparam int unsigned IX_IONE = 24;
  localparam int unsigned NREG    = 25;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_D_ALL, ACT_D_PROC, ACT_D_ONE, ACT_D_FILL,
    ACT_I_ALL, ACT_I_PROC, ACT_I_ONE, ACT_I_FILL
  } act_e;

  typedef enum logic [1:0] {RD_PLAIN, RD_CYC, RD_DPTE, RD_CONST} rdk_e;

  typedef struct packed {
    logic          rd_ok;
    logic          wr_ok;
    logic [DW-1:0] wmask;
    act_e          act;
    rdk_e          rdk;
  } attr_t;

  function automatic attr_t lookup(input int unsigned ix);
    attr_t a;
    a.rd_ok = 1'b1;
    a.wr_ok = 1'b1;
    a.wmask = '1;
    a.act   = ACT_NONE;
    a.rdk   = RD_PLAIN;
    case (ix)
      IX_SCR0, IX_SCR1, IX_ITAG: ;
      IX_TREQ, IX_TEN:  a.wmask = 64'hF;
      IX_PRI:           a.wmask = 64'h1F;
      IX_IMOD, IX_DMOD: a.wmask = 64'h18;
      IX_SWI:           a.wmask = 64'h7FFF0;
      IX_EPC:           a.wmask = ~64'h2;
      IX_ESUM, IX_EMSK: a.wmask = '0;
      IX_CYC:           a.rdk   = RD_CYC;
      IX_CORE: begin a.wr_ok = 1'b0; a.rdk = RD_CONST; end
      IX_DASN:          a.wmask = DASN_MASK;
      IX_IASN:          a.wmask = IASN_MASK;
      IX_DPTE:          a.rdk   = RD_DPTE;
      IX_DTAG: begin a.rd_ok = 1'b0; a.act = ACT_D_FILL; end
      IX_IPTE: begin a.rd_ok = 1'b0; a.act = ACT_I_FILL; end
      IX_DALL: begin a.rd_ok = 1'b0; a.wmask = '0; a.act = ACT_D_ALL;  end
      IX_DPRC: begin a.rd_ok = 1'b0; a.wmask = '0; a.act = ACT_D_PROC; end
      IX_DONE: begin a.rd_ok = 1'b0; a.act = ACT_D_ONE; end
      IX_IALL: begin a.rd_ok = 1'b0; a.wmask = '0; a.act = ACT_I_ALL;  end
      IX_IPRC: begin a.rd_ok = 1'b0; a.wmask = '0; a.act = ACT_I_PROC; end
      IX_IONE: begin a.rd_ok = 1'b0; a.act = ACT_I_ONE; end
      default: begin a.rd_ok = 1'b0; a.wr_ok = 1'b0; a.wmask = '0; end
    endcase
    return a;
  endfunction

  function automatic logic [ENT_W-1:0] pack_ent(input logic [ASN_W-1:0] asn,
                                                input logic [DW-1:0] pte,
                                                input logic kill_wr);
    logic [EN_W-1:0] wen;
    wen = kill_wr ? '0 : pte[WREN_LSB +: EN_W];
    return {asn, pte[PPN_LSB +: PPN_W], pte[RDEN_LSB +: EN_W], wen,
            pte[ANY_BIT], pte[FOW_BIT], pte[FOR_BIT]};
  endfunction
endpackage

// File: rtl/preg_store.sv
module preg_store
  import preg_pkg::*;
#(
  parameter int unsigned IW = 6,
  parameter int unsigned N  = NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] q [N]
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[g] <= '0;
      else if (we && widx == IW'(g))       q[g] <= wval;
    end
  end
endmodule

// File: rtl/preg_rdmux.sv
module preg_rdmux
  import preg_pkg::*;
#(
  parameter int unsigned   IW = 6,
  parameter int unsigned   N  = NREG,
  parameter logic [DW-1:0] ID = '0
) (
  input  logic [IW-1:0]       idx,
  input  logic [DW-1:0]       q [N],
  input  logic [CYC_LO_W-1:0] cnt,
  output logic [DW-1:0]       data,
  output logic                fault
);
  attr_t         a;
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++)
      if (idx == IW'(i)) sel = q[i];
  end

  always_comb begin
    a     = lookup(32'(idx));
    fault = !a.rd_ok;
    data  = '0;
    if (a.rd_ok) begin
      unique case (a.rdk)
        RD_PLAIN: data = sel;
        RD_CYC:   data = {q[IX_CYC][DW-1:CYC_LO_W], cnt};
        RD_DPTE:  data = (q[IX_DPTE] & PTE_FIELDS) | (q[IX_DASN] & DASN_MASK);
        RD_CONST: data = ID;
        default:  data = '0;
      endcase
    end
  end
endmodule

// File: rtl/preg_xlat.sv
module preg_xlat
  import preg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  act_e             act,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    dpte,
  input  logic [DW-1:0]    dasn_r,
  input  logic [DW-1:0]    iasn_r,
  input  logic [DW-1:0]    itag,
  output logic             block,
  output logic             fill_err,
  output logic             d_inv_all,
  output logic             d_inv_proc,
  output logic             d_inv_one,
  output logic [DW-1:0]    d_inv_addr,
  output logic [ASN_W-1:0] d_inv_asn,
  output logic             d_fill_vld,
  output logic [DW-1:0]    d_fill_tag,
  output logic [ENT_W-1:0] d_fill_ent,
  output logic             i_inv_all,
  output logic             i_inv_proc,
  output logic             i_inv_one,
  output logic [DW-1:0]    i_inv_addr,
  output logic [ASN_W-1:0] i_inv_asn,
  output logic             i_fill_vld,
  output logic [DW-1:0]    i_fill_tag,
  output logic [ENT_W-1:0] i_fill_ent
);
  logic [ASN_W-1:0] asn_d, asn_i;
  logic             gh_d, gh_i;

  assign asn_d = dasn_r[DASN_LSB +: ASN_W];
  assign asn_i = iasn_r[IASN_LSB +: ASN_W];
  assign gh_d  = |dpte[GH_LSB +: GH_W];
  assign gh_i  = |wdata[GH_LSB +: GH_W];
  assign block = go && ((act == ACT_D_FILL && gh_d) || (act == ACT_I_FILL && gh_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_err   <= 1'b0;
      d_inv_all  <= 1'b0; d_inv_proc <= 1'b0; d_inv_one <= 1'b0;
      d_inv_addr <= '0;   d_inv_asn  <= '0;
      d_fill_vld <= 1'b0; d_fill_tag <= '0;   d_fill_ent <= '0;
      i_inv_all  <= 1'b0; i_inv_proc <= 1'b0; i_inv_one <= 1'b0;
      i_inv_addr <= '0;   i_inv_asn  <= '0;
      i_fill_vld <= 1'b0; i_fill_tag <= '0;   i_fill_ent <= '0;
    end else begin
      fill_err   <= block;
      d_inv_all  <= 1'b0; d_inv_proc <= 1'b0; d_inv_one <= 1'b0; d_fill_vld <= 1'b0;
      i_inv_all  <= 1'b0; i_inv_proc <= 1'b0; i_inv_one <= 1'b0; i_fill_vld <= 1'b0;
      if (go && !block) begin
        case (act)
          ACT_D_ALL:  d_inv_all  <= 1'b1;
          ACT_D_PROC: d_inv_proc <= 1'b1;
          ACT_D_ONE: begin
            d_inv_one  <= 1'b1;
            d_inv_addr <= wdata;
            d_inv_asn  <= asn_d;
          end
          ACT_D_FILL: begin
            d_fill_vld <= 1'b1;
            d_fill_tag <= wdata;
            d_fill_ent <= pack_ent(asn_d, dpte, 1'b0);
          end
          ACT_I_ALL:  i_inv_all  <= 1'b1;
          ACT_I_PROC: i_inv_proc <= 1'b1;
          ACT_I_ONE: begin
            i_inv_one  <= 1'b1;
            i_inv_addr <= wdata;
            i_inv_asn  <= asn_i;
          end
          ACT_I_FILL: begin
            i_fill_vld <= 1'b1;
            i_fill_tag <= itag;
            i_fill_ent <= pack_ent(asn_i, wdata, 1'b1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/preg_bank.sv
module preg_bank
  import preg_pkg::*;
#(
  parameter int unsigned   IDX_W   = 6,
  parameter logic [63:0]   CORE_ID = 64'h0000_0001_C0DE_0042
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_vld,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rsp_vld,
  output logic [63:0]        rsp_data,
  output logic               rsp_fault,
  input  logic               wr_vld,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [63:0]        wr_data,
  output logic               wr_fault,
  output logic               fill_err,
  output logic               d_inv_all,
  output logic               d_inv_proc,
  output logic               d_inv_one,
  output logic [63:0]        d_inv_addr,
  output logic [6:0]         d_inv_asn,
  output logic               d_fill_vld,
  output logic [63:0]        d_fill_tag,
  output logic [44:0]        d_fill_ent,
  output logic               i_inv_all,
  output logic               i_inv_proc,
  output logic               i_inv_one,
  output logic [63:0]        i_inv_addr,
  output logic [6:0]         i_inv_asn,
  output logic               i_fill_vld,
  output logic [63:0]        i_fill_tag,
  output logic [44:0]        i_fill_ent
);
  logic [DW-1:0]       q [NREG];
  logic [CYC_LO_W-1:0] cyc_cnt;
  attr_t               wa;
  logic                wgo, blk, we;
  logic [DW-1:0]       wval;
  logic [DW-1:0]       rdata;
  logic                rfault;

  assign wa   = lookup(32'(wr_idx));
  assign wgo  = wr_vld && wa.wr_ok;
  assign we   = wgo && !blk;
  assign wval = wr_data & wa.wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_cnt <= '0;
    else        cyc_cnt <= cyc_cnt + 1'b1;
  end

  preg_store #(.IW(IDX_W), .N(NREG)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (we),
    .widx (wr_idx),
    .wval (wval),
    .q    (q)
  );

  preg_rdmux #(.IW(IDX_W), .N(NREG), .ID(CORE_ID)) u_rdmux (
    .idx  (rd_idx),
    .q    (q),
    .cnt  (cyc_cnt),
    .data (rdata),
    .fault(rfault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_data  <= '0;
      rsp_fault <= 1'b0;
      wr_fault  <= 1'b0;
    end else begin
      rsp_vld   <= rd_vld;
      rsp_data  <= rd_vld ? rdata : '0;
      rsp_fault <= rd_vld && rfault;
      wr_fault  <= wr_vld && !wa.wr_ok;
    end
  end

  preg_xlat u_xlat (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (wgo),
    .act       (wa.act),
    .wdata     (wr_data),
    .dpte      (q[IX_DPTE]),
    .dasn_r    (q[IX_DASN]),
    .iasn_r    (q[IX_IASN]),
    .itag      (q[IX_ITAG]),
    .block     (blk),
    .fill_err  (fill_err),
    .d_inv_all (d_inv_all),
    .d_inv_proc(d_inv_proc),
    .d_inv_one (d_inv_one),
    .d_inv_addr(d_inv_addr),
    .d_inv_asn (d_inv_asn),
    .d_fill_vld(d_fill_vld),
    .d_fill_tag(d_fill_tag),
    .d_fill_ent(d_fill_ent),
    .i_inv_all (i_inv_all),
    .i_inv_proc(i_inv_proc),
    .i_inv_one (i_inv_one),
    .i_inv_addr(i_inv_addr),
    .i_inv_asn (i_inv_asn),
    .i_fill_vld(i_fill_vld),
    .i_fill_tag(i_fill_tag),
    .i_fill_ent(i_fill_ent)
  );
endmodule

// File: rtl/preg_bank_chk.sv
module preg_bank_chk
  import preg_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_vld,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rsp_vld,
  input logic [63:0]      rsp_data,
  input logic             rsp_fault,
  input logic             wr_vld,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_fault,
  input logic             fill_err,
  input logic             d_inv_all,
  input logic             d_inv_proc,
  input logic             d_inv_one,
  input logic             d_fill_vld,
  input logic             i_inv_all,
  input logic             i_inv_proc,
  input logic             i_inv_one,
  input logic             i_fill_vld,
  input logic [44:0]      i_fill_ent
);
  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |=> rsp_vld);

  p_wfault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> $past(wr_vld));

  p_rdonly_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_idx == IDX_W'(IX_CORE)) |=> wr_fault);

  p_unknown_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_idx >= IDX_W'(NREG)) |=> (rsp_fault && rsp_data == '0));

  p_flush_all_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d_inv_all |-> $past(wr_vld && wr_idx == IDX_W'(IX_DALL)));

  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_inv_all, d_inv_proc, d_inv_one, d_fill_vld,
              i_inv_all, i_inv_proc, i_inv_one, i_fill_vld, fill_err}));

  p_dfill_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_fill_vld |-> $past(wr_vld && wr_idx == IDX_W'(IX_DTAG)));

  p_ifill_nowrite_r13: assert property (@(posedge clk) disable iff (!rst_n)
    i_fill_vld |-> (i_fill_ent[6:3] == 4'b0));
endmodule

bind preg_bank preg_bank_chk #(.IDX_W(IDX_W)) u_preg_bank_chk (.*);

// File: tb/test_preg_bank.sv
module test_preg_bank;
  localparam logic [63:0] CID = 64'h0000_0001_C0DE_0042;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_vld = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic        rsp_vld, rsp_fault;
  logic [63:0] rsp_data;
  logic        wr_vld = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_fault, fill_err;
  logic        d_inv_all, d_inv_proc, d_inv_one, d_fill_vld;
  logic        i_inv_all, i_inv_proc, i_inv_one, i_fill_vld;
  logic [63:0] d_inv_addr, i_inv_addr, d_fill_tag, i_fill_tag;
  logic [6:0]  d_inv_asn, i_inv_asn;
  logic [44:0] d_fill_ent, i_fill_ent;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  preg_bank #(.IDX_W(6), .CORE_ID(CID)) i_preg_bank (.*);

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_vld = 1'b1; wr_idx = 6'(idx); wr_data = d;
    @(posedge clk); #1;
    wr_vld = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] d, output logic f);
    @(negedge clk);
    rd_vld = 1'b1; rd_idx = 6'(idx);
    @(posedge clk); #1;
    rd_vld = 1'b0;
    d = rsp_data; f = rsp_fault;
  endtask

  function automatic logic [44:0] ent(input logic [6:0] asn, input logic [63:0] p, input bit kill);
    return {asn, p[58:32], p[11:8], kill ? 4'b0 : p[15:12], p[4], p[2], p[1]};
  endfunction

  task automatic t_reset;
    logic [63:0] d; logic f;
    check("R1 flush idle", {d_inv_all, i_inv_all, d_fill_vld, i_fill_vld, wr_fault, fill_err}, 0);
    rd(0, d, f);
    check("R1 scratch zero", d, 0);
    rd(15, d, f);
    check("R1 staged entry zero", d, 0);
  endtask

  task automatic t_plain;
    logic [63:0] d; logic f;
    wr(0, 64'hDEAD_BEEF_0123_4567);
    rd(0, d, f);
    check("R3 scratch0", d, 64'hDEAD_BEEF_0123_4567);
    wr(17, 64'hFFFF_0000_AAAA_5555);
    rd(17, d, f);
    check("R3 itag", d, 64'hFFFF_0000_AAAA_5555);
  endtask

  task automatic t_latency;
    logic [63:0] d; logic f;
    wr(1, 64'h1111);
    @(negedge clk);
    rd_vld = 1'b1; rd_idx = 6'd1;
    wr_vld = 1'b1; wr_idx = 6'd1; wr_data = 64'h2222;
    @(posedge clk); #1;
    rd_vld = 1'b0; wr_vld = 1'b0;
    check("R2 rsp valid", 64'(rsp_vld), 1);
    check("R2 old value on collision", rsp_data, 64'h1111);
    @(posedge clk); #1;
    check("R2 rsp one cycle", 64'(rsp_vld), 0);
    rd(1, d, f);
    check("R2 new value after", d, 64'h2222);
  endtask

  task automatic t_masks;
    logic [63:0] d; logic f;
    int          ix [8] = '{2, 3, 4, 5, 6, 7, 13, 14};
    logic [63:0] mk [8] = '{64'hF, 64'hF, 64'h1F, 64'h18, 64'h18, 64'h7FFF0,
                            64'hFE00_0000_0000_0000, 64'h7F0};
    for (int k = 0; k < 8; k++) begin
      wr(ix[k], '1);
      rd(ix[k], d, f);
      check($sformatf("R4 mask idx %0d", ix[k]), d, mk[k]);
    end
  endtask

  task automatic t_exc;
    logic [63:0] d; logic f;
    wr(8, 64'h1234_5678_9ABC_DEFF);
    rd(8, d, f);
    check("R5 epc bit1", d, 64'h1234_5678_9ABC_DEFD);
    wr(9, '1);
    rd(9, d, f);
    check("R5 summary clears", d, 0);
    wr(10, 64'h55);
    rd(10, d, f);
    check("R5 mask clears", d, 0);
  endtask

  task automatic t_fault;
    logic [63:0] d; logic f;
    wr(12, 64'h77);
    check("R6 write read-only", 64'(wr_fault), 1);
    rd(12, d, f);
    check("R6 read-only value", d, CID);
    check("R6 read-only no fault", 64'(f), 0);
    wr(40, 64'h1);
    check("R6 write unknown", 64'(wr_fault), 1);
    rd(40, d, f);
    check("R6 read unknown fault", 64'(f), 1);
    check("R6 read unknown data", d, 0);
    rd(19, d, f);
    check("R6 read write-only", 64'(f), 1);
    wr(0, 64'h9);
    check("R6 legal write no fault", 64'(wr_fault), 0);
  endtask

  task automatic t_cyc;
    logic [63:0] d1, d2; logic f;
    wr(11, 64'hABCD_0000_1234_5678);
    rd(11, d1, f);
    rd(11, d2, f);
    check("R7 upper half", {32'b0, d1[63:32]}, 64'hABCD_0000);
    check("R7 counter step", 64'(d2[31:0] - d1[31:0]), 1);
  endtask

  task automatic t_inv;
    wr(19, 64'h5);
    check("R8 data flush all", {d_inv_all, d_inv_proc, i_inv_all, i_inv_proc}, 64'b1000);
    @(posedge clk); #1;
    check("R8 pulse one cycle", 64'(d_inv_all), 0);
    wr(20, 64'h5);
    check("R8 data flush proc", {d_inv_all, d_inv_proc, i_inv_all, i_inv_proc}, 64'b0100);
    wr(22, 64'h5);
    check("R8 instr flush all", {d_inv_all, d_inv_proc, i_inv_all, i_inv_proc}, 64'b0010);
    wr(23, 64'h5);
    check("R8 instr flush proc", {d_inv_all, d_inv_proc, i_inv_all, i_inv_proc}, 64'b0001);
  endtask

  task automatic t_inv_one;
    wr(13, 64'(7'h15) << 57);
    wr(21, 64'h0000_0000_0010_2000);
    check("R9 data single strobe", 64'(d_inv_one), 1);
    check("R9 data addr", d_inv_addr, 64'h0000_0000_0010_2000);
    check("R9 data asn", 64'(d_inv_asn), 64'h15);
    wr(14, 64'(7'h2A) << 4);
    wr(24, 64'h8000_0000_0000_4000);
    check("R9 instr single strobe", 64'(i_inv_one), 1);
    check("R9 instr addr", i_inv_addr, 64'h8000_0000_0000_4000);
    check("R9 instr asn", 64'(i_inv_asn), 64'h2A);
  endtask

  task automatic t_dfill;
    logic [63:0] d; logic f;
    logic [63:0] pte;
    pte = (64'(27'h5A5A5A5) << 32) | 64'h5A00 | 64'h12 | 64'h0010_0001;
    wr(13, 64'(7'h33) << 57);
    wr(15, pte);
    rd(15, d, f);
    check("R12 packed entry read",
          d, (pte & 64'h07FF_FFFF_0000_FF16) | (64'(7'h33) << 57));
    wr(16, 64'h0000_1234_5678_0000);
    check("R10 data fill strobe", 64'(d_fill_vld), 1);
    check("R10 data fill tag", d_fill_tag, 64'h0000_1234_5678_0000);
    check("R10 data fill entry", 64'(d_fill_ent), 64'(ent(7'h33, pte, 1'b0)));
    check("R10 no error", 64'(fill_err), 0);
  endtask

  task automatic t_gh;
    wr(15, 64'h20 | 64'h300);
    wr(16, 64'hCAFE);
    check("R11 data fill error", 64'(fill_err), 1);
    check("R11 data no fill", 64'(d_fill_vld), 0);
    wr(18, 64'h40);
    check("R11 instr fill error", 64'(fill_err), 1);
    check("R11 instr no fill", 64'(i_fill_vld), 0);
  endtask

  task automatic t_ifill;
    logic [63:0] pte;
    pte = (64'(27'h1234567) << 32) | 64'hF300 | 64'h16;
    wr(14, 64'(7'h4C) << 4);
    wr(17, 64'h0000_0000_FEED_0000);
    wr(18, pte);
    check("R13 instr fill strobe", 64'(i_fill_vld), 1);
    check("R13 instr fill tag", i_fill_tag, 64'h0000_0000_FEED_0000);
    check("R13 instr fill entry", 64'(i_fill_ent), 64'(ent(7'h4C, pte, 1'b1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_plain();
    t_latency();
    t_masks();
    t_exc();
    t_fault();
    t_cyc();
    t_inv();
    t_inv_one();
    t_dfill();
    t_gh();
    t_ifill();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule